// File: doc/BRIEF.md
# Cascadable Shift-In/Shift-Out FIFO Cell

This block is a first-in first-out buffer of 64 words of 9 bits. Words enter on a single-cycle shift-in strobe and leave on a single-cycle shift-out strobe. Two ready outputs describe the state of the buffer. The input-side ready says that a word can be taken in. The output-side ready says that the word at the data output is valid. Two level flags give a coarse view of the fill: a half-full flag, and a single flag that warns when the buffer is close to either end.

Everything runs on one clock with a synchronous active-low master reset. The ready outputs come straight from registered state, so cells can be chained in depth with no glue logic. Each upstream output-ready drives the downstream shift-in, and each upstream data output drives the downstream data input. Each downstream input-ready drives the upstream shift-out. A cell built as an intermediate stage (`LAST_STAGE = 0`) keeps one location free for the word crossing to the next stage. A chain of N cells therefore stores N×63+1 words.

Top module: `ssfifo_cell`

## Requirements
- R1: A final-stage cell accepts at most 64 words. `in_ready` is high while fewer than 64 words are stored and low at 64.
- R2: `out_ready` is high exactly while at least one word is stored. It goes low in the cycle after the last word is shifted out.
- R3: Words leave in the order they entered. While `out_ready` is high, `dout` shows the oldest stored word.
- R4: `half_full` is high when 32 or more words are stored and low at 31 or fewer.
- R5: `near_limit` is high when 8 or fewer words are stored or when 56 or more are stored. It is low for counts from 9 to 55.
- R6: If `mr_n` is low at a rising clock edge, the buffer is empty after that edge. Then `in_ready`=1, `out_ready`=0, `half_full`=0 and `near_limit`=1.
- R7: When shift-in and shift-out are both strobed in one cycle with the buffer neither empty nor full, both are honoured and the word count does not change.
- R8: A shift-in while `in_ready` is low, or a shift-out while `out_ready` is low, has no effect on the stored words or on any flag.
- R9: An intermediate cell (`LAST_STAGE = 0`) drops `in_ready` at 63 words. A chain of one intermediate cell and one final cell accepts exactly 127 words before its input ready goes low.
- R10: In a chain, word order is preserved end to end under any pattern of shift-in and shift-out strobes at the two ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mr_n | input | 1 | Master reset, synchronous, active low |
| shift_in | input | 1 | Single-cycle strobe that writes `din` |
| din | input | 9 | Word to be written |
| in_ready | output | 1 | A word can be accepted |
| shift_out | input | 1 | Single-cycle strobe that removes the word at `dout` |
| dout | output | 9 | Oldest stored word |
| out_ready | output | 1 | `dout` holds a valid word |
| half_full | output | 1 | 32 or more words stored |
| near_limit | output | 1 | 8 or fewer, or 56 or more, words stored |

## Verification
The bench fills a single cell one word at a time from empty to full and drains it again. After every step it compares all four flags with the expected word count. An off-by-one in any threshold would therefore show at 8/9, 31/32, 55/56 or 63/64. Strobes made against a full or an empty cell must leave the flags and the later output order unchanged. A design that wrote past the end or popped a phantom word would corrupt the sequence that is read back. A paired push and pop at mid fill must keep the flags steady. A design that let one strobe win would drift the count.

A two-stage chain is then filled until it refuses input. Exactly 127 words must be accepted: a non-final stage that kept all 64 locations would reach 128. Random strobes at both ends of the chain then check, against a reference queue, that every word comes out in order.

// File: rtl/ssfifo_pkg.sv
// Shared constants and types for the shift-in/shift-out FIFO cell.
// Assumes: depth is a power of two so that pointers wrap naturally.
package ssfifo_pkg;
    localparam int unsigned WORD_W     = 9;
    localparam int unsigned CELL_DEPTH = 64;

    // Strobes that actually take effect in a cycle
    typedef struct packed {
        logic push;
        logic pop;
    } xfer_t;
endpackage

// File: rtl/ssfifo_store.sv
// Word storage with read and write pointers.
// Assumes: push only when space exists and pop only when a word exists.
// These are guaranteed by the caller. DEPTH is a power of two.
// The read port is combinational, so the oldest word is always visible.
module ssfifo_store #(
    parameter int unsigned WIDTH = 9,
    parameter int unsigned DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ssfifo_pkg::xfer_t xf,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Write the incoming word into the slot at the write pointer
    always_ff @(posedge clk) begin
        if (xf.push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance the pointers on accepted strobes; reset returns both to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (xf.push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (xf.pop)  rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    // Present the oldest word
    always_comb begin
        rd_data = mem[rd_ptr];
    end
endmodule

// File: rtl/ssfifo_level.sv
// Occupancy counter and the flags derived from it.
// Assumes: push/pop are already qualified by room/avail.
// LIMIT is the number of words this cell may hold (DEPTH, or DEPTH-1 for a
// stage that reserves a slot for inter-stage transfer).
module ssfifo_level #(
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned LIMIT     = 64,
    parameter int unsigned HALF_MARK = 32,
    parameter int unsigned LOW_MARK  = 8,
    parameter int unsigned HIGH_MARK = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ssfifo_pkg::xfer_t xf,
    output logic              room,
    output logic              avail,
    output logic              half,
    output logic              near
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(HALF_MARK);
    localparam logic [CNT_W-1:0] LOW_C   = CNT_W'(LOW_MARK);
    localparam logic [CNT_W-1:0] HIGH_C  = CNT_W'(HIGH_MARK);

    logic [CNT_W-1:0] count;

    // Track the number of stored words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({xf.push, xf.pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // Decode ready and level flags from the count
    always_comb begin
        room  = (count < LIMIT_C);
        avail = (count != '0);
        half  = (count >= HALF_C);
        near  = (count <= LOW_C) || (count >= HIGH_C);
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIMIT_C);

    // R7
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xf.push && xf.pop) |=> $stable(count));

    // R2
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xf.pop && !xf.push && count == CNT_W'(1)) |=> !avail);
endmodule

// File: rtl/ssfifo_cell.sv
// Cascadable shift-in/shift-out FIFO cell.
// Assumes: single clock domain, synchronous active-low master reset.
// The ready outputs depend only on registered state, so chaining
// out_ready->shift_in and in_ready->shift_out forms no combinational loop.
// Set LAST_STAGE=0 on every cell except the one at the output of a chain.
module ssfifo_cell
    import ssfifo_pkg::*;
#(
    parameter int unsigned WIDTH      = WORD_W,
    parameter int unsigned DEPTH      = CELL_DEPTH,
    parameter int unsigned HALF_MARK  = DEPTH / 2,
    parameter int unsigned LOW_MARK   = 8,
    parameter int unsigned HIGH_MARK  = DEPTH - 8,
    parameter bit          LAST_STAGE = 1'b1
) (
    input  logic             clk,
    input  logic             mr_n,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             shift_out,
    output logic [WIDTH-1:0] dout,
    output logic             out_ready,
    output logic             half_full,
    output logic             near_limit
);
    localparam int unsigned LIMIT = LAST_STAGE ? DEPTH : DEPTH - 1;

    xfer_t xf;

    // Qualify the strobes with the ready flags
    always_comb begin
        xf.push = shift_in  && in_ready;
        xf.pop  = shift_out && out_ready;
    end

    ssfifo_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (mr_n),
        .xf      (xf),
        .wr_data (din),
        .rd_data (dout)
    );

    ssfifo_level #(
        .DEPTH     (DEPTH),
        .LIMIT     (LIMIT),
        .HALF_MARK (HALF_MARK),
        .LOW_MARK  (LOW_MARK),
        .HIGH_MARK (HIGH_MARK)
    ) u_level (
        .clk   (clk),
        .rst_n (mr_n),
        .xf    (xf),
        .room  (in_ready),
        .avail (out_ready),
        .half  (half_full),
        .near  (near_limit)
    );

    // R8
    blocked_fill_chk: assert property (@(posedge clk) disable iff (!mr_n)
        (shift_in && !in_ready && !shift_out)
            |=> (!in_ready && $stable(half_full) && $stable(near_limit)));
endmodule

// File: tb/ssfifo_cell_test.sv
`timescale 1ns/1ps
module ssfifo_cell_test;
    logic       clk = 1'b0;
    logic       mr_n = 1'b0;
    logic       si = 1'b0, so = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       in_ready, out_ready, half_full, near_limit;

    // chain signals
    logic       c_si = 1'b0, c_so = 1'b0;
    logic [8:0] c_din = '0;
    logic [8:0] mid_data, c_dout;
    logic       mid_valid, mid_ready, c_in_ready, c_out_ready;
    logic       h0, n0, h1, n1;

    int checks = 0;
    int errors = 0;
    logic [8:0] q[$];
    logic [8:0] cq[$];

    always #4 clk = ~clk;

    ssfifo_cell uut (
        .clk(clk), .mr_n(mr_n), .shift_in(si), .din(din), .in_ready(in_ready),
        .shift_out(so), .dout(dout), .out_ready(out_ready),
        .half_full(half_full), .near_limit(near_limit));

    ssfifo_cell #(.LAST_STAGE(1'b0)) stage0 (
        .clk(clk), .mr_n(mr_n), .shift_in(c_si), .din(c_din), .in_ready(c_in_ready),
        .shift_out(mid_ready), .dout(mid_data), .out_ready(mid_valid),
        .half_full(h0), .near_limit(n0));

    ssfifo_cell stage1 (
        .clk(clk), .mr_n(mr_n), .shift_in(mid_valid), .din(mid_data), .in_ready(mid_ready),
        .shift_out(c_so), .dout(c_dout), .out_ready(c_out_ready),
        .half_full(h1), .near_limit(n1));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare {in_ready,out_ready,half_full,near_limit} with a stored count n
    task automatic flags_chk(input int n, input string req);
        logic [3:0] exp, act;
        exp = {n < 64, n > 0, n >= 32, (n <= 8) || (n >= 56)};
        act = {in_ready, out_ready, half_full, near_limit};
        chk(act == exp, req, act, exp);
    endtask

    // One cycle on the single cell, updating the reference queue
    task automatic step(input logic s_in, input logic s_out, input logic [8:0] d);
        si = s_in; so = s_out; din = d;
        #1;
        if (s_out && out_ready) begin
            chk(q.size() > 0 && dout == q[0], "R3", dout, (q.size() > 0) ? q[0] : 0);
            if (q.size() > 0) void'(q.pop_front());
        end
        if (s_in && in_ready) q.push_back(d);
        @(posedge clk); #2;
        si = 1'b0; so = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int acc;
        repeat (3) @(posedge clk);
        #2;
        // R6: state after reset
        flags_chk(0, "R6");
        chk(c_in_ready && !c_out_ready, "R6", {c_in_ready, c_out_ready}, 2'b10);
        mr_n = 1'b1;
        @(posedge clk); #2;

        // R1 R4 R5: fill sweep from empty to full
        for (int i = 0; i < 64; i++) begin
            step(1'b1, 1'b0, 9'(i * 37 + 5));
            flags_chk(q.size(), "R1 R4 R5 fill");
        end
        chk(q.size() == 64, "R1", q.size(), 64);
        // R8: push while full is ignored
        step(1'b1, 1'b0, 9'h1AA);
        flags_chk(64, "R8 full push");
        // R2 R3 R4 R5: drain sweep to 40
        for (int i = 0; i < 24; i++) begin
            step(1'b0, 1'b1, '0);
            flags_chk(q.size(), "R2 R4 R5 drain");
        end
        // R7: paired strobes at mid fill
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 1'b1, 9'(300 + i));
            flags_chk(40, "R7");
        end
        // R3 R5 R2: drain to empty
        while (q.size() > 0) begin
            step(1'b0, 1'b1, '0);
            flags_chk(q.size(), "R2 R5 drain");
        end
        // R8: pop while empty is ignored
        step(1'b0, 1'b1, '0);
        flags_chk(0, "R8 empty pop");
        step(1'b1, 1'b0, 9'h0F3);
        flags_chk(1, "R2");
        chk(dout == 9'h0F3, "R8 R3", dout, 9'h0F3);
        // R6: reset mid fill
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 9'(i));
        mr_n = 1'b0;
        @(posedge clk); #2;
        mr_n = 1'b1;
        q.delete();
        flags_chk(0, "R6 mid reset");

        // R9: chain capacity
        acc = 0;
        for (int i = 0; i < 300; i++) begin
            c_si = 1'b1; c_din = 9'(i);
            #1;
            if (c_in_ready) begin
                cq.push_back(c_din);
                acc++;
            end
            @(posedge clk); #2;
        end
        c_si = 1'b0;
        chk(acc == 127, "R9", acc, 127);
        chk(!c_in_ready, "R9", c_in_ready, 0);

        // R10: random strobes at both ends of the chain
        for (int i = 0; i < 4000; i++) begin
            c_si = 1'($urandom_range(0, 1));
            c_so = 1'($urandom_range(0, 2) != 0);
            c_din = 9'($urandom);
            #1;
            if (c_so && c_out_ready) begin
                chk(cq.size() > 0 && c_dout == cq[0], "R10", c_dout, (cq.size() > 0) ? cq[0] : 0);
                if (cq.size() > 0) void'(cq.pop_front());
            end
            if (c_si && c_in_ready) cq.push_back(c_din);
            @(posedge clk); #2;
        end
        c_si = 1'b0;
        for (int i = 0; i < 600 && cq.size() > 0; i++) begin
            c_so = 1'b1;
            #1;
            if (c_out_ready) begin
                chk(c_dout == cq[0], "R10", c_dout, cq[0]);
                void'(cq.pop_front());
            end
            @(posedge clk); #2;
        end
        c_so = 1'b0;
        chk(cq.size() == 0, "R10", cq.size(), 0);
        chk(!c_out_ready, "R10 R2", c_out_ready, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule